// File: doc/BRIEF.md
# Serial Link Integrity Monitor

This block sits beside the serial command port of a multi-channel converter and judges whether each received command frame can be trusted. It receives the command bits after they have been brought into the system clock domain, one strobe per bit, along with a frame-start pulse and a frame-end strobe. When packet error checking is switched on, a frame is 32 bits long: a 24-bit command followed by an 8-bit CRC. The block recomputes the CRC over the command bits and passes the command on as a register write only when the check succeeds. Any failure is recorded as a packet error.

An inactivity watchdog measures how long it has been since the last frame started. If the host stays silent beyond a programmable timeout, an active-high alert is raised. The next accepted frame clears the alert. Packet errors and three analog condition flags from the output stage feed a set of sticky status bits. These bits drive a single request that pulls the active-low, open-drain fault pin low. A status bit is cleared only when it is read while its source is inactive.

Top module: `link_integrity_monitor`

## Requirements
- R1: With `pec_en`=1, a frame of exactly 32 bits is accepted when its last 8 bits equal the CRC of its first 24 bits. The CRC uses polynomial x^8+x^2+x+1 (0x07), starts from zero and takes bits MSB first. Acceptance is a one-cycle `wr_vld` pulse in the cycle after `frame_end`, with the first 24 bits, first bit as MSB, on `wr_data`.
- R2: With `pec_en`=0, a frame of exactly 24 bits is accepted in the same way and no CRC is expected.
- R3: With `pec_en`=1, a CRC mismatch or a length other than 32 bits produces no `wr_vld`. It produces a one-cycle `pec_err` pulse in the cycle after `frame_end`, sets status bit 0 one cycle later and asserts `fault_pull`.
- R4: With `pec_en`=0, a frame whose length is not 24 bits is dropped: no `wr_vld` and no `pec_err`.
- R5: With `wdt_en`=1, `alert` rises at the clock edge T+1 after the last `sync_fall`, where T is `TICKS_PER_MS` times 5, 10, 100 or 200 for `wdt_sel` = 0, 1, 2 or 3. It stays low before that edge. With `wdt_en`=0, `alert` never rises.
- R6: An accepted frame clears `alert` in the cycle after `wr_vld`. A rejected frame leaves `alert` set.
- R7: `status` holds sticky bits: bit 0 for a packet error, bit 1 for overtemperature, bit 2 for an open circuit and bit 3 for a short circuit. A bit sets one cycle after its source is seen. A one-cycle `status_rd` clears a bit only when its source is inactive on that cycle.
- R8: `open_flag` counts only while `chan_cur_mode`=1 (current output). `short_flag` counts only while `chan_cur_mode`=0 (voltage output).
- R9: `fault_pull` is high exactly while any status bit is set. It stays high until every source has cleared and the status has been read.
- R10: While reset is held, `wr_vld`, `pec_err`, `alert`, `fault_pull` and `status` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_fall | input | 1 | One-cycle pulse at frame start; restarts the frame and the watchdog |
| bit_vld | input | 1 | Strobe for one received serial bit |
| bit_val | input | 1 | Value of the received bit |
| frame_end | input | 1 | One-cycle pulse marking the end of a frame |
| pec_en | input | 1 | Enables the 8-bit CRC trailer check |
| wdt_en | input | 1 | Enables the inactivity watchdog |
| wdt_sel | input | 2 | Timeout select: 5, 10, 100 or 200 ms |
| chan_cur_mode | input | 1 | 1 = current output mode, 0 = voltage output mode |
| ot_flag | input | 1 | Overtemperature condition |
| open_flag | input | 1 | Open-circuit condition on the current output |
| short_flag | input | 1 | Short-circuit condition on the voltage output |
| status_rd | input | 1 | Status read strobe (clear-on-read) |
| wr_vld | output | 1 | Accepted-frame write pulse |
| wr_data | output | 24 | Command payload of the accepted frame |
| pec_err | output | 1 | Packet error pulse |
| alert | output | 1 | Inactivity alert, active high |
| fault_pull | output | 1 | 1 = pull the open-drain active-low fault pin low |
| status | output | 4 | Sticky status bits |

## Verification
The assertions check the following on every cycle:
- a write only ever follows a frame-end strobe;
- a packet error never comes with a write, and it always leaves bit 0 and the fault request set;
- the alert cannot rise while the watchdog is disabled, and an accepted frame always drops it;
- the fault request does not fall without a status read;
- an open-circuit bit can only appear in current mode.

Some behaviour only the bench scenarios can show:
- the CRC value itself;
- the exact timeout edge for each select setting;
- clear-on-read being refused while a source is still active;
- the payload carried by randomly generated good and corrupted frames.

// File: rtl/lim_pkg.sv
package lim_pkg;
  localparam int unsigned PAYLOAD_W = 24;
  localparam int unsigned CRC_W     = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

  localparam int unsigned NUM_SRC  = 4;
  localparam int unsigned ST_PEC   = 0;
  localparam int unsigned ST_OT    = 1;
  localparam int unsigned ST_OPEN  = 2;
  localparam int unsigned ST_SHORT = 3;

  typedef enum logic [1:0] {
    TMO_5MS   = 2'd0,
    TMO_10MS  = 2'd1,
    TMO_100MS = 2'd2,
    TMO_200MS = 2'd3
  } tmo_sel_e;
endpackage

// File: rtl/lim_frame_check.sv
module lim_frame_check #(
  parameter int unsigned PAY_W = 24,
  parameter int unsigned CHK_W = 8,
  parameter logic [CHK_W-1:0] POLY = 8'h07
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic             bit_vld,
  input  logic             bit_val,
  input  logic             frame_end,
  input  logic             pec_en,
  output logic             wr_vld,
  output logic [PAY_W-1:0] wr_data,
  output logic             pec_err
);
  localparam int unsigned FRAME_W = PAY_W + CHK_W;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LEN_PEC  = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] LEN_RAW  = CNT_W'(PAY_W);

  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic [CHK_W-1:0]   crc_q, crc_d, crc_step;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               fb;
  logic               good, bad;
  logic [PAY_W-1:0]   pay_sel;

  // one serial step of the CRC register, MSB first
  always_comb begin
    fb       = crc_q[CHK_W-1] ^ bit_val;
    crc_step = {crc_q[CHK_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  always_comb begin
    shreg_d = shreg_q;
    crc_d   = crc_q;
    cnt_d   = cnt_q;
    if (frame_start) begin
      shreg_d = '0;
      crc_d   = '0;
      cnt_d   = '0;
    end else if (bit_vld) begin
      shreg_d = {shreg_q[FRAME_W-2:0], bit_val};
      if (cnt_q < LEN_RAW) crc_d = crc_step;
      if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
    end
  end

  always_comb begin
    if (pec_en) begin
      good    = (cnt_q == LEN_PEC) && (shreg_q[CHK_W-1:0] == crc_q);
      bad     = !good;
      pay_sel = shreg_q[FRAME_W-1:CHK_W];
    end else begin
      good    = (cnt_q == LEN_RAW);
      bad     = 1'b0;
      pay_sel = shreg_q[PAY_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      crc_q   <= '0;
      cnt_q   <= '0;
      wr_vld  <= 1'b0;
      pec_err <= 1'b0;
      wr_data <= '0;
    end else begin
      shreg_q <= shreg_d;
      crc_q   <= crc_d;
      cnt_q   <= cnt_d;
      wr_vld  <= frame_end && good;
      pec_err <= frame_end && bad;
      if (frame_end && good) wr_data <= pay_sel;
    end
  end
endmodule

// File: rtl/lim_watchdog.sv
module lim_watchdog #(
  parameter int unsigned TICKS_PER_MS = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] sel,
  input  logic       restart,
  input  logic       clr,
  output logic       alert
);
  import lim_pkg::*;
  localparam int unsigned LIM_MAX = 200 * TICKS_PER_MS;
  localparam int unsigned CNT_W   = $clog2(LIM_MAX + 2);
  localparam logic [CNT_W-1:0] LIM0 = CNT_W'(5   * TICKS_PER_MS);
  localparam logic [CNT_W-1:0] LIM1 = CNT_W'(10  * TICKS_PER_MS);
  localparam logic [CNT_W-1:0] LIM2 = CNT_W'(100 * TICKS_PER_MS);
  localparam logic [CNT_W-1:0] LIM3 = CNT_W'(LIM_MAX);

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             alert_d;
  logic             reached;

  always_comb begin
    unique case (tmo_sel_e'(sel))
      TMO_5MS:   limit = LIM0;
      TMO_10MS:  limit = LIM1;
      TMO_100MS: limit = LIM2;
      default:   limit = LIM3;
    endcase
  end

  assign reached = (cnt_q >= limit);

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !en)  cnt_d = '0;
    else if (!reached)   cnt_d = cnt_q + 1'b1;

    alert_d = alert;
    if (clr)                alert_d = 1'b0;
    else if (en && reached) alert_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      alert <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      alert <= alert_d;
    end
  end
endmodule

// File: rtl/lim_fault_agg.sv
module lim_fault_agg #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic         rd,
  output logic [N-1:0] status,
  output logic         fault_pull
);
  logic [N-1:0] st_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb st_d[i] = src[i] | (status[i] & ~rd);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status[i] <= 1'b0;
      else        status[i] <= st_d[i];
    end
  end

  assign fault_pull = |status;
endmodule

// File: rtl/link_integrity_monitor.sv
module link_integrity_monitor #(
  parameter int unsigned TICKS_PER_MS = 100000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sync_fall,
  input  logic                          bit_vld,
  input  logic                          bit_val,
  input  logic                          frame_end,
  input  logic                          pec_en,
  input  logic                          wdt_en,
  input  logic [1:0]                    wdt_sel,
  input  logic                          chan_cur_mode,
  input  logic                          ot_flag,
  input  logic                          open_flag,
  input  logic                          short_flag,
  input  logic                          status_rd,
  output logic                          wr_vld,
  output logic [lim_pkg::PAYLOAD_W-1:0] wr_data,
  output logic                          pec_err,
  output logic                          alert,
  output logic                          fault_pull,
  output logic [lim_pkg::NUM_SRC-1:0]   status
);
  import lim_pkg::*;

  logic [NUM_SRC-1:0] src;

  always_comb begin
    src           = '0;
    src[ST_PEC]   = pec_err;
    src[ST_OT]    = ot_flag;
    src[ST_OPEN]  = open_flag & chan_cur_mode;
    src[ST_SHORT] = short_flag & ~chan_cur_mode;
  end

  lim_frame_check #(
    .PAY_W (PAYLOAD_W),
    .CHK_W (CRC_W),
    .POLY  (CRC_POLY)
  ) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (sync_fall),
    .bit_vld     (bit_vld),
    .bit_val     (bit_val),
    .frame_end   (frame_end),
    .pec_en      (pec_en),
    .wr_vld      (wr_vld),
    .wr_data     (wr_data),
    .pec_err     (pec_err)
  );

  lim_watchdog #(
    .TICKS_PER_MS (TICKS_PER_MS)
  ) u_wdt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (wdt_en),
    .sel     (wdt_sel),
    .restart (sync_fall),
    .clr     (wr_vld),
    .alert   (alert)
  );

  lim_fault_agg #(
    .N (NUM_SRC)
  ) u_fault (
    .clk        (clk),
    .rst_n      (rst_n),
    .src        (src),
    .rd         (status_rd),
    .status     (status),
    .fault_pull (fault_pull)
  );
endmodule

// File: rtl/lim_checker.sv
module lim_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_end,
  input logic       wdt_en,
  input logic       chan_cur_mode,
  input logic       open_flag,
  input logic       status_rd,
  input logic       wr_vld,
  input logic       pec_err,
  input logic       alert,
  input logic       fault_pull,
  input logic [3:0] status
);
  AST_WR_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld |-> $past(frame_end)); // R1

  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pec_err |-> !wr_vld); // R3

  AST_ERR_SETS_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    pec_err |=> (fault_pull && status[0])); // R3

  AST_ALERT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert) |-> $past(wdt_en)); // R5

  AST_GOOD_FRAME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld |=> !alert); // R6

  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_pull && !status_rd) |=> fault_pull); // R9

  AST_OPEN_IN_CUR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> $past(open_flag && chan_cur_mode)); // R8
endmodule

bind link_integrity_monitor lim_checker u_lim_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_end     (frame_end),
  .wdt_en        (wdt_en),
  .chan_cur_mode (chan_cur_mode),
  .open_flag     (open_flag),
  .status_rd     (status_rd),
  .wr_vld        (wr_vld),
  .pec_err       (pec_err),
  .alert         (alert),
  .fault_pull    (fault_pull),
  .status        (status)
);

// File: tb/tb_link_integrity_monitor.sv
`timescale 1ns/1ps
module tb_link_integrity_monitor;
  localparam int TPM = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic sync_fall, bit_vld, bit_val, frame_end, pec_en, wdt_en;
  logic [1:0] wdt_sel;
  logic chan_cur_mode, ot_flag, open_flag, short_flag, status_rd;
  logic wr_vld, pec_err, alert, fault_pull;
  logic [23:0] wr_data;
  logic [3:0] status;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  link_integrity_monitor #(.TICKS_PER_MS(TPM)) dut (
    .clk(clk), .rst_n(rst_n), .sync_fall(sync_fall), .bit_vld(bit_vld),
    .bit_val(bit_val), .frame_end(frame_end), .pec_en(pec_en),
    .wdt_en(wdt_en), .wdt_sel(wdt_sel), .chan_cur_mode(chan_cur_mode),
    .ot_flag(ot_flag), .open_flag(open_flag), .short_flag(short_flag),
    .status_rd(status_rd), .wr_vld(wr_vld), .wr_data(wr_data),
    .pec_err(pec_err), .alert(alert), .fault_pull(fault_pull),
    .status(status)
  );

  function automatic logic [7:0] calc_crc(input logic [23:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 23; i >= 0; i--) begin
      logic f = c[7] ^ d[i];
      c = {c[6:0], 1'b0};
      if (f) c = c ^ 8'h07;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // sends len bits of w (MSB first); returns after the frame_end cycle,
  // at the negedge following the edge that registers the result
  task automatic send(input logic [31:0] w, input int len);
    sync_fall = 1'b1; tick(1); sync_fall = 1'b0;
    for (int i = len - 1; i >= 0; i--) begin
      bit_vld = 1'b1; bit_val = w[i]; tick(1);
    end
    bit_vld = 1'b0; bit_val = 1'b0;
    frame_end = 1'b1; tick(1); frame_end = 1'b0;
  endtask

  task automatic read_status();
    status_rd = 1'b1; tick(1); status_rd = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog timeout actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [23:0] pay;
    logic [7:0]  crc;
    void'($urandom(32'd4242));
    rst_n = 1'b0; sync_fall = 0; bit_vld = 0; bit_val = 0; frame_end = 0;
    pec_en = 0; wdt_en = 0; wdt_sel = 0; chan_cur_mode = 1;
    ot_flag = 0; open_flag = 0; short_flag = 0; status_rd = 0;
    tick(3);
    // R10 reset state
    chk(!wr_vld && !pec_err && !alert && !fault_pull && status == 0, "R10",
        {wr_vld, pec_err, alert, fault_pull, status}, 0);
    rst_n = 1'b1; tick(2);

    // R1 directed good frame with CRC
    pec_en = 1; pay = 24'hA5_3C_0F; crc = calc_crc(pay);
    send({pay, crc}, 32);
    chk(wr_vld && !pec_err, "R1", {wr_vld, pec_err}, 2'b10);
    chk(wr_data == pay, "R1", wr_data, pay);
    tick(1);
    chk(!wr_vld && status == 0 && !fault_pull, "R1", {wr_vld, status}, 0);

    // R3 corrupted CRC
    send({pay, crc ^ 8'h01}, 32);
    chk(!wr_vld && pec_err, "R3", {wr_vld, pec_err}, 2'b01);
    tick(1);
    chk(status[0] && fault_pull, "R3", {status, fault_pull}, 5'b00011);
    read_status();
    chk(status == 0 && !fault_pull, "R9", {status, fault_pull}, 0);

    // R3 wrong length with CRC on
    send({pay, 8'h00}, 31);
    chk(!wr_vld && pec_err, "R3", {wr_vld, pec_err}, 2'b01);
    tick(1); read_status();

    // R2 / R4 without CRC
    pec_en = 0; pay = 24'h00_FF_81;
    send({8'h00, pay}, 24);
    chk(wr_vld && !pec_err && wr_data == pay, "R2", wr_data, pay);
    send({8'h00, pay}, 25);
    chk(!wr_vld && !pec_err, "R4", {wr_vld, pec_err}, 0);
    tick(1);
    chk(status == 0, "R4", status, 0);

    // random frames
    for (int n = 0; n < 60; n++) begin
      int  len;
      bit  pe, corrupt, exp_ok, exp_err;
      pe = $urandom_range(0, 1);
      pay = $urandom();
      corrupt = ($urandom_range(0, 3) == 0);
      pec_en = pe;
      if (pe) begin
        crc = calc_crc(pay) ^ (corrupt ? 8'(1 << $urandom_range(0, 7)) : 8'h00);
        len = ($urandom_range(0, 7) == 0) ? 33 : 32;
        send({pay, crc}, len);
        exp_ok = !corrupt && len == 32; exp_err = !exp_ok;
      end else begin
        len = ($urandom_range(0, 7) == 0) ? 23 : 24;
        send({8'h00, pay}, len);
        exp_ok = (len == 24); exp_err = 0;
      end
      chk(wr_vld == exp_ok && pec_err == exp_err, pe ? "R3" : "R4",
          {wr_vld, pec_err}, {exp_ok, exp_err});
      if (exp_ok) chk(wr_data == pay, pe ? "R1" : "R2", wr_data, pay);
      tick(1);
      chk(status[0] == exp_err && fault_pull == exp_err, "R9",
          {status[0], fault_pull}, {exp_err, exp_err});
      if (exp_err) read_status();
    end

    // R5 watchdog timing, select 0 (5 ms)
    pec_en = 0; wdt_en = 1; wdt_sel = 2'd0;
    sync_fall = 1'b1; tick(1); sync_fall = 1'b0;
    tick(5 * TPM - 1);
    chk(!alert, "R5", alert, 0);
    tick(4);
    chk(alert, "R5", alert, 1);
    // R6 bad frame keeps alert, good frame clears it
    pec_en = 1;
    send(32'h0, 20);
    tick(1);
    chk(alert, "R6", alert, 1);
    read_status();
    pec_en = 0;
    send({8'h00, 24'h123456}, 24);
    tick(1);
    chk(!alert, "R6", alert, 0);

    // R5 select 1 (10 ms)
    wdt_sel = 2'd1;
    sync_fall = 1'b1; tick(1); sync_fall = 1'b0;
    tick(10 * TPM - 1);
    chk(!alert, "R5", alert, 0);
    tick(4);
    chk(alert, "R5", alert, 1);
    send({8'h00, 24'h000001}, 24); tick(1);

    // R5 select 3 (200 ms)
    wdt_sel = 2'd3;
    sync_fall = 1'b1; tick(1); sync_fall = 1'b0;
    tick(200 * TPM - 1);
    chk(!alert, "R5", alert, 0);
    tick(4);
    chk(alert, "R5", alert, 1);
    send({8'h00, 24'h000002}, 24); tick(1);

    // R5 disabled
    wdt_en = 0; wdt_sel = 2'd0;
    tick(20 * TPM);
    chk(!alert, "R5", alert, 0);

    // R8 mode gating
    chan_cur_mode = 0; open_flag = 1; tick(3);
    chk(status[2] == 0 && !fault_pull, "R8", status, 0);
    open_flag = 0; short_flag = 1; tick(2);
    chk(status[3] && fault_pull, "R8", status, 4'b1000);
    // R7 read while source active keeps the bit
    read_status();
    chk(status[3], "R7", status, 4'b1000);
    short_flag = 0; tick(1);
    chk(status[3] && fault_pull, "R9", {status, fault_pull}, 5'b10001);
    read_status();
    chk(status == 0 && !fault_pull, "R7", {status, fault_pull}, 0);
    chan_cur_mode = 1; open_flag = 1; tick(2);
    chk(status == 4'b0100, "R8", status, 4'b0100);
    open_flag = 0; ot_flag = 1; tick(2);
    chk(status == 4'b0110, "R7", status, 4'b0110);
    ot_flag = 0; read_status();
    chk(status == 0 && !fault_pull, "R9", {status, fault_pull}, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule